// File: doc/BRIEF.md
# Extensible Stack Pointer Unit

This block holds the stack pointer of an 8051-style core. Out of reset it is an ordinary 8-bit pointer that stays inside the 256-byte internal RAM. When the extended-mode input is high, the block adds a 3-bit high extension, which makes the pointer 11 bits wide. In that mode the stack can grow past FFh into the extended data RAM, where it starts at 0100h and can reach 07FFh.

The core raises a push strobe for push and call, and a pop strobe for pop and return. A push increments the pointer and then uses the new value as its address. A pop uses the current pointer as its address and decrements the pointer afterwards. For the access in the current cycle, the block drives the physical stack address and a select line that steers it to either internal RAM or extended RAM. A small special-function-register port reads and writes the low byte at 81h and the high extension at B7h. The B7h register is locked while extended mode is off.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the low pointer byte reads 07h at register address 81h, and the high extension reads 00h at B7h once extended mode is on.
- R2: While push_i is high, with pop_i low and no stack-register write in the same cycle, stack_addr_o equals the pointer plus one. After the clock edge the pointer holds that value. The first push after reset therefore addresses 08h.
- R3: While pop_i is high, with push_i low and no stack-register write in the same cycle, stack_addr_o equals the current pointer. After the clock edge the pointer is one lower.
- R4: With ext_en_i low, the pointer wraps within 8 bits: a push from FFh gives 00h and a pop from 00h gives FFh. stack_addr_o[10:8] stays 0 and xram_sel_o stays 0.
- R5: With ext_en_i high, a push from 00FFh addresses 0100h with xram_sel_o = 1. A pop from 0100h leaves the pointer at 00FFh.
- R6: With ext_en_i high, a push from 07FFh gives 0000h and a pop from 0000h gives 07FFh.
- R7: xram_sel_o is 1 exactly when ext_en_i is high and stack_addr_o[10:8] is nonzero.
- R8: A write to 81h loads the low byte. With ext_en_i high, a write to B7h loads wdata[2:0] into the high extension. A read of B7h returns the extension in bits [2:0] and zeros in bits [7:3].
- R9: With ext_en_i low, writes to B7h are ignored and reads of B7h return 00h.
- R10: While ext_en_i is low, the high extension is forced to zero, so a value set earlier is gone when the mode is enabled again.
- R11: A write to 81h or B7h in the same cycle as a push or pop wins. The strobe is discarded, and the pointer takes the written value.
- R12: When push_i and pop_i are high together, the pointer does not change and stack_addr_o equals the current pointer.
- R13: Reads of any other register address return 00h, and writes to them leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_en_i | input | 1 | Extended 11-bit mode enable (configuration bit) |
| push_i | input | 1 | Push or call strobe |
| pop_i | input | 1 | Pop or return strobe |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address for read and write |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read data (combinational) |
| stack_addr_o | output | 11 | Physical stack address for this cycle's access |
| xram_sel_o | output | 1 | 1 selects extended RAM, 0 selects internal RAM |

## Verification
The hardest states to reach are the boundaries of the 11-bit space: crossing between 00FFh and 0100h, and the full wrap between 07FFh and 0000h. Reaching them with pushes alone would take up to two thousand strobes. The bench instead uses the register port to load the high extension and the low byte directly, and then issues a single push or pop. Where a write is required to have no effect, the bench checks this by toggling the mode and reading the register back afterwards.

// File: rtl/stack_ptr_pkg.sv
package stack_ptr_pkg;
  localparam int LO_W  = 8;
  localparam int HI_W  = 3;
  localparam int PTR_W = LO_W + HI_W;
  localparam logic [7:0] RST_LO = 8'h07;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;
endpackage

// File: rtl/stack_sfr_port.sv
module stack_sfr_port
  import stack_ptr_pkg::*;
#(
  parameter logic [7:0] LO_ADDR = 8'h81,
  parameter logic [7:0] HI_ADDR = 8'hB7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_en_i,
  input  logic            sfr_we_i,
  input  logic [7:0]      sfr_addr_i,
  input  logic [LO_W-1:0] lo_q_i,
  input  logic [HI_W-1:0] hi_q_i,
  output logic            wr_lo_o,
  output logic            wr_hi_o,
  output logic            blk_o,
  output logic [7:0]      sfr_rdata_o
);
  logic hit_lo, hit_hi;
  assign hit_lo  = sfr_addr_i == LO_ADDR;
  assign hit_hi  = sfr_addr_i == HI_ADDR;
  assign wr_lo_o = sfr_we_i && hit_lo;
  assign wr_hi_o = sfr_we_i && hit_hi && ext_en_i;
  // any write aimed at a stack register suppresses push/pop
  assign blk_o   = sfr_we_i && (hit_lo || hit_hi);

  always_comb begin
    sfr_rdata_o = '0;
    if (hit_lo)               sfr_rdata_o[LO_W-1:0] = lo_q_i;
    else if (hit_hi && ext_en_i) sfr_rdata_o[HI_W-1:0] = hi_q_i;
  end

  p_hi_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_hi && !ext_en_i) |-> (sfr_rdata_o == 8'h00 && !wr_hi_o));
  p_hi_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_hi |-> (sfr_rdata_o[7:HI_W] == '0));
endmodule

// File: rtl/stack_ptr_reg.sv
module stack_ptr_reg
  import stack_ptr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_en_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             blk_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [7:0]       wdata_i,
  output logic [LO_W-1:0]  lo_q_o,
  output logic [HI_W-1:0]  hi_q_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] ptr_inc_o,
  output step_e            step_o
);
  logic [LO_W-1:0]  lo_q, lo_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic [PTR_W-1:0] ptr, ptr_inc, ptr_dec, ptr_nxt;
  step_e            step;

  assign ptr     = {(ext_en_i ? hi_q : {HI_W{1'b0}}), lo_q};
  assign ptr_inc = ptr + PTR_W'(1);
  assign ptr_dec = ptr - PTR_W'(1);

  always_comb begin
    step = STEP_HOLD;
    if (!blk_i && push_i && !pop_i) step = STEP_INC;
    if (!blk_i && pop_i && !push_i) step = STEP_DEC;
  end

  always_comb begin
    unique case (step)
      STEP_INC: ptr_nxt = ptr_inc;
      STEP_DEC: ptr_nxt = ptr_dec;
      default:  ptr_nxt = ptr;
    endcase
    lo_d = ptr_nxt[LO_W-1:0];
    hi_d = ext_en_i ? ptr_nxt[PTR_W-1:LO_W] : '0;
    if (wr_lo_i) lo_d = wdata_i[LO_W-1:0];
    if (wr_hi_i) hi_d = wdata_i[HI_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= RST_LO;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_q_o    = lo_q;
  assign hi_q_o    = hi_q;
  assign ptr_o     = ptr;
  assign ptr_inc_o = ext_en_i ? ptr_inc : {{HI_W{1'b0}}, ptr_inc[LO_W-1:0]};
  assign step_o    = step;

  p_hi_cleared_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_en_i |=> (hi_q == '0));
  p_wr_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (lo_q == $past(wdata_i[LO_W-1:0])));
  p_both_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !blk_i && !wr_hi_i) |=> (lo_q == $past(lo_q)));
  p_narrow_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_en_i && push_i && !pop_i && !blk_i && lo_q == 8'hFF) |=> (lo_q == 8'h00));
endmodule

// File: rtl/stack_addr_map.sv
module stack_addr_map
  import stack_ptr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_en_i,
  input  step_e            step_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [PTR_W-1:0] ptr_inc_i,
  output logic [PTR_W-1:0] stack_addr_o,
  output logic             xram_sel_o
);
  // push addresses the pre-incremented slot, everything else the current one
  assign stack_addr_o = (step_i == STEP_INC) ? ptr_inc_i : ptr_i;
  assign xram_sel_o   = ext_en_i && (stack_addr_o[PTR_W-1:LO_W] != '0);

  p_sel_needs_ext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xram_sel_o |-> ext_en_i);
  p_narrow_stays_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_en_i |-> (stack_addr_o[PTR_W-1:LO_W] == '0 && !xram_sel_o));
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stack_ptr_pkg::*;
#(
  parameter logic [7:0] LO_ADDR = 8'h81,
  parameter logic [7:0] HI_ADDR = 8'hB7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_en_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              sfr_we_i,
  input  logic [7:0]        sfr_addr_i,
  input  logic [7:0]        sfr_wdata_i,
  output logic [7:0]        sfr_rdata_o,
  output logic [PTR_W-1:0]  stack_addr_o,
  output logic              xram_sel_o
);
  logic             wr_lo, wr_hi, blk;
  logic [LO_W-1:0]  lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [PTR_W-1:0] ptr, ptr_inc;
  step_e            step;

  stack_sfr_port #(.LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_sfr (
    .clk_i, .rst_ni, .ext_en_i, .sfr_we_i, .sfr_addr_i,
    .lo_q_i(lo_q), .hi_q_i(hi_q),
    .wr_lo_o(wr_lo), .wr_hi_o(wr_hi), .blk_o(blk), .sfr_rdata_o
  );

  stack_ptr_reg u_reg (
    .clk_i, .rst_ni, .ext_en_i, .push_i, .pop_i,
    .blk_i(blk), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(sfr_wdata_i),
    .lo_q_o(lo_q), .hi_q_o(hi_q), .ptr_o(ptr), .ptr_inc_o(ptr_inc), .step_o(step)
  );

  stack_addr_map u_map (
    .clk_i, .rst_ni, .ext_en_i, .step_i(step),
    .ptr_i(ptr), .ptr_inc_i(ptr_inc), .stack_addr_o, .xram_sel_o
  );
endmodule

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_en_i = 1'b0;
  logic        push_i = 1'b0;
  logic        pop_i = 1'b0;
  logic        sfr_we_i = 1'b0;
  logic [7:0]  sfr_addr_i = 8'h00;
  logic [7:0]  sfr_wdata_i = 8'h00;
  logic [7:0]  sfr_rdata_o;
  logic [10:0] stack_addr_o;
  logic        xram_sel_o;
  int checks = 0;
  int errors = 0;

  localparam logic [7:0] A_LO = 8'h81;
  localparam logic [7:0] A_HI = 8'hB7;

  stack_ptr_unit u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    sfr_we_i = 1'b1; sfr_addr_i = a; sfr_wdata_i = d;
    @(negedge clk_i);
    sfr_we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    sfr_addr_i = a;
    #1 d = sfr_rdata_o;
  endtask

  task automatic get_ptr(output logic [10:0] p);
    logic [7:0] l, h;
    rd(A_LO, l);
    rd(A_HI, h);
    p = {h[2:0], l};
  endtask

  task automatic set_ptr(logic [10:0] p);
    wr(A_HI, {5'b0, p[10:8]});
    wr(A_LO, p[7:0]);
  endtask

  task automatic strobe(logic pu, logic po, output logic [10:0] a, output logic s);
    @(negedge clk_i);
    push_i = pu; pop_i = po;
    #1 a = stack_addr_o; s = xram_sel_o;
    @(negedge clk_i);
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    logic [10:0] a;
    logic s;
    rd(A_LO, d);
    chk("R1 reset low byte", d, 8'h07);
    ext_en_i = 1'b1;
    rd(A_HI, d);
    chk("R1 reset high ext", d, 8'h00);
    ext_en_i = 1'b0;
    strobe(1, 0, a, s);
    chk("R2 first push addr", a, 11'h008);
  endtask

  task automatic t_push_pop;
    logic [10:0] a, p;
    logic s;
    set_ptr(11'h040);
    strobe(1, 0, a, s);
    chk("R2 push addr", a, 11'h041);
    get_ptr(p);
    chk("R2 ptr after push", p, 11'h041);
    strobe(0, 1, a, s);
    chk("R3 pop addr", a, 11'h041);
    get_ptr(p);
    chk("R3 ptr after pop", p, 11'h040);
  endtask

  task automatic t_wrap8;
    logic [10:0] a, p;
    logic s;
    ext_en_i = 1'b0;
    wr(A_LO, 8'hFF);
    strobe(1, 0, a, s);
    chk("R4 push FF addr", a, 11'h000);
    chk("R4 sel low", s, 1'b0);
    rd(A_LO, p[7:0]);
    chk("R4 ptr wraps to 00", p[7:0], 8'h00);
    strobe(0, 1, a, s);
    chk("R4 pop at 00 addr", a, 11'h000);
    rd(A_LO, p[7:0]);
    chk("R4 ptr wraps to FF", p[7:0], 8'hFF);
  endtask

  task automatic t_ext_cross;
    logic [10:0] a, p;
    logic s;
    ext_en_i = 1'b1;
    set_ptr(11'h0FF);
    strobe(1, 0, a, s);
    chk("R5 push into xram addr", a, 11'h100);
    chk("R5 R7 sel high", s, 1'b1);
    strobe(0, 1, a, s);
    chk("R7 pop sel at 0100", s, 1'b1);
    get_ptr(p);
    chk("R5 pop to 00FF", p, 11'h0FF);
    strobe(0, 1, a, s);
    chk("R7 sel low at 00FF", s, 1'b0);
  endtask

  task automatic t_ext_wrap;
    logic [10:0] a, p;
    logic s;
    ext_en_i = 1'b1;
    set_ptr(11'h7FF);
    strobe(1, 0, a, s);
    chk("R6 push from 07FF addr", a, 11'h000);
    get_ptr(p);
    chk("R6 ptr 0000", p, 11'h000);
    strobe(0, 1, a, s);
    get_ptr(p);
    chk("R6 pop to 07FF", p, 11'h7FF);
  endtask

  task automatic t_hi_reg;
    logic [7:0] d;
    ext_en_i = 1'b1;
    wr(A_HI, 8'hFD);
    rd(A_HI, d);
    chk("R8 hi reads 3 bits", d, 8'h05);
    wr(A_LO, 8'h3C);
    rd(A_LO, d);
    chk("R8 low write", d, 8'h3C);
  endtask

  task automatic t_hi_locked;
    logic [7:0] d;
    logic [10:0] a;
    logic s;
    ext_en_i = 1'b1;
    wr(A_HI, 8'h00);
    ext_en_i = 1'b0;
    wr(A_HI, 8'h06);
    rd(A_HI, d);
    chk("R9 hi read locked", d, 8'h00);
    strobe(0, 0, a, s);
    chk("R9 addr unaffected", a[10:8], 3'h0);
    ext_en_i = 1'b1;
    rd(A_HI, d);
    chk("R9 write was ignored", d, 8'h00);
  endtask

  task automatic t_disable_clears;
    logic [7:0] d;
    ext_en_i = 1'b1;
    wr(A_HI, 8'h03);
    ext_en_i = 1'b0;
    @(negedge clk_i);
    ext_en_i = 1'b1;
    rd(A_HI, d);
    chk("R10 hi cleared", d, 8'h00);
  endtask

  task automatic t_priority;
    logic [10:0] p;
    ext_en_i = 1'b0;
    wr(A_LO, 8'h20);
    @(negedge clk_i);
    sfr_we_i = 1'b1; sfr_addr_i = A_LO; sfr_wdata_i = 8'h55; push_i = 1'b1;
    @(negedge clk_i);
    sfr_we_i = 1'b0; push_i = 1'b0;
    rd(A_LO, p[7:0]);
    chk("R11 write beats push", p[7:0], 8'h55);
    ext_en_i = 1'b1;
    @(negedge clk_i);
    sfr_we_i = 1'b1; sfr_addr_i = A_HI; sfr_wdata_i = 8'h02; pop_i = 1'b1;
    @(negedge clk_i);
    sfr_we_i = 1'b0; pop_i = 1'b0;
    get_ptr(p);
    chk("R11 hi write beats pop", p, 11'h255);
  endtask

  task automatic t_both;
    logic [10:0] a, p;
    logic s;
    ext_en_i = 1'b1;
    set_ptr(11'h1A0);
    strobe(1, 1, a, s);
    chk("R12 both addr", a, 11'h1A0);
    get_ptr(p);
    chk("R12 both hold", p, 11'h1A0);
  endtask

  task automatic t_other;
    logic [7:0] d;
    logic [10:0] p;
    ext_en_i = 1'b1;
    set_ptr(11'h333);
    wr(8'h82, 8'hAA);
    rd(8'h82, d);
    chk("R13 other read zero", d, 8'h00);
    get_ptr(p);
    chk("R13 other write no effect", p, 11'h333);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_push_pop();
    t_wrap8();
    t_ext_cross();
    t_ext_wrap();
    t_hi_reg();
    t_hi_locked();
    t_disable_clears();
    t_priority();
    t_both();
    t_other();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule